// File: doc/BRIEF.md
# Mode-Switching Memory Address Generator

This block turns raw addresses coming out of a CPU's operand path into final 24-bit memory addresses. It runs in one of two persistent modes. Short mode gives 16-bit register width: the low 16 bits of the raw address are placed inside a 64 KB window, and an 8-bit page register selects that window. Long mode gives flat 24-bit addressing, and the page register plays no part in it. The persistent mode bit can never be loaded as ordinary data. It changes only when the mode-switch pins are pulsed. The core raises those pins for an explicit switch, an interrupt or a trap.

Each request can carry two override controls, and neither one touches the persistent mode. The data-width override makes that one instruction use short or long addressing. The stream override decides whether an immediate of uncertain length takes two or three bytes. The block reports how many immediate bytes to fetch. It also reduces the raw immediate to the value that the instruction really uses.

Requests arrive on a valid/ready channel. Results leave on a valid/ready channel that holds one registered slot. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result stays unchanged. The page write and mode switch are plain control pins. Each request is resolved with the mode and page values that hold at the edge where the request is taken.

Top module: `mmode_agen`

## Requirements
- R1: After reset the block is in short mode (`cur_long`=0) with page 00h, `bp_err`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: When the effective data width is short, `rsp_addr` = {page, req_addr[15:0]}.
- R3: When the effective data width is long, `rsp_addr` = req_addr, whatever the page holds.
- R4: A page write (`bp_wr_en`) while `cur_long`=1 loads `bp_wr_data`. Every request taken after that edge uses the new page.
- R5: A page write while `cur_long`=0 leaves the page unchanged. It raises `bp_err` for exactly the one cycle after that edge.
- R6: `cur_long` takes the value of `mode_sw_long` on an edge where `mode_sw_en`=1. At any other time it keeps its value.
- R7: With `req_dw_ovr`=1 the data width is `req_dw_long` (1 = long) for that request only, and `cur_long` does not change. With `req_dw_ovr`=0 the data width follows `cur_long`.
- R8: The stream length is `req_is_long` when `req_is_ovr`=1 and `cur_long` otherwise. `rsp_imm_bytes` is 3 for a long stream and 2 for a short one.
- R9: For short data with a long stream, `rsp_imm_bytes`=3 and `rsp_imm` = {00h, req_imm[15:0]}.
- R10: For long data with a short stream, `rsp_imm_bytes`=2 and `rsp_imm` = {00h, req_imm[15:0]}.
- R11: For long data with a long stream, `rsp_imm` = req_imm. For short data with a short stream, `rsp_imm` = {00h, req_imm[15:0]}.
- R12: While `rsp_valid`=1 and `rsp_ready`=0 the result stays stable. `req_ready` = !rsp_valid || rsp_ready. Results leave in the order that requests were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sw_en | input | 1 | Persistent mode switch strobe |
| mode_sw_long | input | 1 | New persistent mode (1 = long) |
| bp_wr_en | input | 1 | Page register write request |
| bp_wr_data | input | 8 | Page value to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | 24 | Raw address |
| req_imm | input | 24 | Raw immediate bytes as fetched |
| req_dw_ovr | input | 1 | Data-width override present |
| req_dw_long | input | 1 | Overridden data width (1 = long) |
| req_is_ovr | input | 1 | Stream-length override present |
| req_is_long | input | 1 | Overridden stream length (1 = 3 bytes) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result ready |
| rsp_addr | output | 24 | Final 24-bit address |
| rsp_imm | output | 24 | Effective immediate value |
| rsp_imm_bytes | output | 2 | Immediate byte count (2 or 3) |
| cur_long | output | 1 | Persistent mode bit |
| bp_err | output | 1 | One-cycle pulse for a rejected page write |

## Verification
The bench writes to the page while in short mode and checks that later short addresses still carry the old page. A design that gates the write wrongly would move the short-mode window without warning, and it would also miss the `bp_err` pulse or stretch it past one cycle. The bench exercises all four combinations of data width and stream length. A design that mixes up the two overrides, or that keeps the upper immediate byte for a short-data/long-stream instruction, would show a wrong byte count or a wrong upper immediate byte. It also checks that a request with an override leaves `cur_long` unchanged. The bench then holds back `rsp_ready` in an irregular pattern across back-to-back requests. A design that overwrites its held slot would lose results or return them in the wrong order.

// File: rtl/mmode_agen_pkg.sv
package mmode_agen_pkg;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned SHORT_W  = 16;
  localparam int unsigned PAGE_W   = ADDR_W - SHORT_W;
  localparam int unsigned CNT_W    = 2;
  localparam int unsigned LONG_BYTES  = ADDR_W / 8;
  localparam int unsigned SHORT_BYTES = SHORT_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] imm;
    logic              dw_ovr;
    logic              dw_long;
    logic              is_ovr;
    logic              is_long;
  } agen_req_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] imm;
    logic [CNT_W-1:0]  imm_bytes;
  } agen_rsp_t;
endpackage

// File: rtl/mmode_agen_state.sv
module mmode_agen_state
  import mmode_agen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sw_en,
  input  logic              mode_sw_long,
  input  logic              bp_wr_en,
  input  logic [PAGE_W-1:0] bp_wr_data,
  output logic              mode_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              err_q
);
  logic page_ok;
  assign page_ok = bp_wr_en && mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      page_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (mode_sw_en) mode_q <= mode_sw_long;
      if (page_ok)    page_q <= bp_wr_data;
      err_q <= bp_wr_en && !mode_q;
    end
  end

  assert_page_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_wr_en && mode_q) |=> (page_q == $past(bp_wr_data)));
  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_wr_en && !mode_q) |=> $stable(page_q));
  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_wr_en && !mode_q) |=> err_q);
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_wr_en && !mode_q) |=> !err_q);
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sw_en |=> $stable(mode_q));
endmodule

// File: rtl/mmode_agen_xlate.sv
module mmode_agen_xlate
  import mmode_agen_pkg::*;
(
  input  agen_req_t         req,
  input  logic              mode_q,
  input  logic [PAGE_W-1:0] page_q,
  output agen_rsp_t         rsp
);
  logic data_long;
  logic strm_long;

  assign data_long = req.dw_ovr ? req.dw_long : mode_q;
  assign strm_long = req.is_ovr ? req.is_long : mode_q;

  always_comb begin
    rsp.addr = data_long ? req.addr : {page_q, req.addr[SHORT_W-1:0]};
    rsp.imm  = (data_long && strm_long) ? req.imm
                                        : {{PAGE_W{1'b0}}, req.imm[SHORT_W-1:0]};
    rsp.imm_bytes = strm_long ? CNT_W'(LONG_BYTES) : CNT_W'(SHORT_BYTES);
  end
endmodule

// File: rtl/mmode_agen_slot.sv
module mmode_agen_slot
  import mmode_agen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  output logic      in_ready,
  input  agen_rsp_t in_data,
  output logic      out_valid,
  input  logic      out_ready,
  output agen_rsp_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/mmode_agen.sv
module mmode_agen
  import mmode_agen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sw_en,
  input  logic              mode_sw_long,
  input  logic              bp_wr_en,
  input  logic [PAGE_W-1:0] bp_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_imm,
  input  logic              req_dw_ovr,
  input  logic              req_dw_long,
  input  logic              req_is_ovr,
  input  logic              req_is_long,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_imm,
  output logic [CNT_W-1:0]  rsp_imm_bytes,
  output logic              cur_long,
  output logic              bp_err
);
  logic              mode_q;
  logic [PAGE_W-1:0] page_q;
  agen_req_t         req_s;
  agen_rsp_t         xl_rsp;
  agen_rsp_t         out_rsp;

  assign req_s = '{addr: req_addr, imm: req_imm, dw_ovr: req_dw_ovr,
                   dw_long: req_dw_long, is_ovr: req_is_ovr, is_long: req_is_long};

  mmode_agen_state u_state (
    .clk(clk), .rst_n(rst_n),
    .mode_sw_en(mode_sw_en), .mode_sw_long(mode_sw_long),
    .bp_wr_en(bp_wr_en), .bp_wr_data(bp_wr_data),
    .mode_q(mode_q), .page_q(page_q), .err_q(bp_err)
  );

  mmode_agen_xlate u_xlate (
    .req(req_s), .mode_q(mode_q), .page_q(page_q), .rsp(xl_rsp)
  );

  mmode_agen_slot u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(xl_rsp),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(out_rsp)
  );

  assign rsp_addr      = out_rsp.addr;
  assign rsp_imm       = out_rsp.imm;
  assign rsp_imm_bytes = out_rsp.imm_bytes;
  assign cur_long      = mode_q;

  assert_ovr_no_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_dw_ovr && !mode_sw_en) |=> $stable(cur_long));
endmodule

// File: tb/tb_mmode_agen.sv
module tb_mmode_agen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sw_en = 1'b0, mode_sw_long = 1'b0;
  logic bp_wr_en = 1'b0;
  logic [7:0] bp_wr_data = '0;
  logic req_valid = 1'b0, req_ready;
  logic [23:0] req_addr = '0, req_imm = '0;
  logic req_dw_ovr = 1'b0, req_dw_long = 1'b0, req_is_ovr = 1'b0, req_is_long = 1'b0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [23:0] rsp_addr, rsp_imm;
  logic [1:0] rsp_imm_bytes;
  logic cur_long, bp_err;

  int total = 0, bad = 0;
  bit finished = 0;
  bit stall_on = 0;
  int stall_cnt = 0;
  logic m_long = 1'b0;
  logic [7:0] m_page = 8'h00;
  logic [49:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  mmode_agen dut (
    .clk(clk), .rst_n(rst_n), .mode_sw_en(mode_sw_en), .mode_sw_long(mode_sw_long),
    .bp_wr_en(bp_wr_en), .bp_wr_data(bp_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_imm(req_imm),
    .req_dw_ovr(req_dw_ovr), .req_dw_long(req_dw_long),
    .req_is_ovr(req_is_ovr), .req_is_long(req_is_long),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_imm(rsp_imm),
    .rsp_imm_bytes(rsp_imm_bytes), .cur_long(cur_long), .bp_err(bp_err)
  );

  task automatic check(input bit ok, input string req, input logic [49:0] act, input logic [49:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // backpressure generator
  always begin
    @(posedge clk); #1;
    if (stall_on) begin
      stall_cnt++;
      rsp_ready = (stall_cnt % 3 == 0) || (stall_cnt % 7 == 1);
    end else rsp_ready = 1'b1;
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [49:0] held_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held && rsp_valid)
        check({rsp_addr, rsp_imm, rsp_imm_bytes} == held_val, "R12 hold",
              {rsp_addr, rsp_imm, rsp_imm_bytes}, held_val);
      if (held && !rsp_valid)
        check(1'b0, "R12 dropped", 50'd0, held_val);
      check(req_ready == (!rsp_valid || rsp_ready), "R12 ready", {49'd0, req_ready},
            {49'd0, (!rsp_valid || rsp_ready)});
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R12 unexpected result",
                                     {rsp_addr, rsp_imm, rsp_imm_bytes}, 50'd0);
        else begin
          logic [49:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_addr, rsp_imm, rsp_imm_bytes} == e, t,
                {rsp_addr, rsp_imm, rsp_imm_bytes}, e);
        end
        held = 1'b0;
      end else if (rsp_valid) begin
        held = 1'b1;
        held_val = {rsp_addr, rsp_imm, rsp_imm_bytes};
      end else held = 1'b0;
    end
  end

  task automatic send(input logic [23:0] a, input logic [23:0] im, input logic dwo,
                      input logic dwl, input logic iso, input logic isl, input string tag);
    logic dl, sl;
    logic [23:0] ea, ei;
    logic [1:0]  eb;
    dl = dwo ? dwl : m_long;
    sl = iso ? isl : m_long;
    ea = dl ? a : {m_page, a[15:0]};
    ei = (dl && sl) ? im : {8'h00, im[15:0]};
    eb = sl ? 2'd3 : 2'd2;
    exp_q.push_back({ea, ei, eb});
    tag_q.push_back(tag);
    req_addr = a; req_imm = im; req_dw_ovr = dwo; req_dw_long = dwl;
    req_is_ovr = iso; req_is_long = isl; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        @(posedge clk); #1;
        req_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk); mode_sw_en = 1'b1; mode_sw_long = v;
    @(posedge clk); #1; mode_sw_en = 1'b0;
    m_long = v;
    check(cur_long == v, "R6 mode switch", {49'd0, cur_long}, {49'd0, v});
    @(posedge clk); #1;
    check(cur_long == v, "R6 mode held", {49'd0, cur_long}, {49'd0, v});
  endtask

  task automatic write_page(input logic [7:0] d);
    logic ok;
    ok = m_long;
    @(negedge clk); bp_wr_en = 1'b1; bp_wr_data = d;
    @(posedge clk); #1; bp_wr_en = 1'b0;
    if (ok) m_page = d;
    check(bp_err == !ok, ok ? "R4 no err" : "R5 err pulse", {49'd0, bp_err}, {49'd0, !ok});
    @(posedge clk); #1;
    check(bp_err == 1'b0, "R5 err one cycle", {49'd0, bp_err}, 50'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cur_long == 1'b0, "R1 mode", {49'd0, cur_long}, 50'd0);
    check(bp_err == 1'b0, "R1 err", {49'd0, bp_err}, 50'd0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", {49'd0, rsp_valid}, 50'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(req_ready == 1'b1, "R1 ready", {49'd0, req_ready}, 50'd1);
    // R1 page 00h, R2 short default, R8 2 bytes, R11 short/short
    send(24'hAB1234, 24'hC0FFEE, 0, 0, 0, 0, "R1 R2 R11 short default");
    // R5 rejected page write in short mode
    write_page(8'h77);
    send(24'h33BEEF, 24'h123456, 0, 0, 0, 0, "R5 page unchanged");
    drain();
    set_mode(1'b1);
    // R3 / R8 / R11 long default
    send(24'hFEDCBA, 24'h89ABCD, 0, 0, 0, 0, "R3 R8 R11 long default");
    write_page(8'h5A);
    send(24'h010203, 24'h040506, 0, 0, 0, 0, "R3 page ignored in long");
    // R7 data short override in long mode -> new page R4
    send(24'hFF4321, 24'hAAAAAA, 1, 0, 0, 0, "R4 R7 short override uses page");
    // R10 long data short stream
    send(24'h112233, 24'h998877, 0, 0, 1, 0, "R10 long data short stream");
    drain();
    check(cur_long == 1'b1, "R7 mode unchanged", {49'd0, cur_long}, 50'd1);
    set_mode(1'b0);
    send(24'h00ABCD, 24'h000011, 0, 0, 0, 0, "R2 R4 short with page");
    send(24'h9A8B7C, 24'h5E6F70, 1, 1, 0, 0, "R7 long override in short");
    send(24'h123456, 24'hFEDCBA, 0, 0, 1, 1, "R9 short data long stream");
    send(24'h7654FE, 24'h3210AB, 1, 1, 1, 1, "R11 long/long override");
    drain();
    check(cur_long == 1'b0, "R7 mode unchanged", {49'd0, cur_long}, 50'd0);
    // R12 backpressure with back-to-back traffic
    stall_on = 1;
    for (int i = 0; i < 24; i++)
      send(24'(i * 24'h050B13 + 24'h0A0B0C), 24'(i * 24'h11F3A7), i[0], i[1], i[2], i[3],
           "R12 ordered under stall");
    drain();
    stall_on = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule